// File: doc/BRIEF.md
# Interrupt Level, Error Mode and Reset Qualifier

This block sits next to a processor core and owns three pieces of control. It takes a 4-bit external interrupt level that arrives with no relation to the core clock. It passes that level through a chain of flip-flops and compares it with the core's current interrupt priority and trap-enable bit. When the interrupt should be taken, it raises a take request. A level of zero means idle. The all-ones level cannot be masked by priority.

The block also holds a sticky error mode. The core enters error mode when it reports a synchronous trap while traps are disabled. Only a qualified reset clears it. The reset request is registered first. It takes effect only after it has stayed high for a minimum number of clocks. When it is released, the block drives a one-cycle start pulse with a fetch address of zero.

The controller has four states:
- `ST_RESET`: the core is held in reset.
- `ST_BOOT`: a single cycle that emits the start pulse.
- `ST_RUN`: normal execution.
- `ST_ERROR`: halted in error mode.

Its transitions are:
- reset-release: `ST_RESET` to `ST_BOOT`.
- boot-done: `ST_BOOT` to `ST_RUN`.
- trap-while-disabled: `ST_RUN` to `ST_ERROR`.
- qualified-reset: any state to `ST_RESET`.

Top module: `irq_err_rst_ctrl`

## Requirements
- R1: `irq_level_o` equals the value that `irq_lvl_i` held two rising clock edges earlier. The input passes through two register stages.
- R2: A synchronised level of 0 (binary 0000) never produces `irq_take_o`.
- R3: `irq_take_o` is asserted only while `trap_en_i` is 1 and the controller is in `ST_RUN`.
- R4: A maskable level from 1 to 14 is taken only when it is strictly greater than `pil_i` (unsigned compare).
- R5: Level 15 (binary 1111) is taken whatever the value of `pil_i`, including when `pil_i` is also 15.
- R6: A `sync_trap_i` pulse in `ST_RUN` with `trap_en_i`=0 sets `err_o` at the next edge. The same pulse with `trap_en_i`=1 leaves `err_o` at 0.
- R7: Once set, `err_o` stays at 1 until a qualified reset. No interrupt is taken while it is 1.
- R8: `rst_req_i` is registered before use. When it is held at 1 for at least 8 consecutive rising edges, `core_rst_o` goes to 1 and `err_o` goes to 0.
- R9: A `rst_req_i` pulse covering fewer than 8 edges is ignored. `core_rst_o` stays 0, no start pulse is given, and `err_o` keeps its value.
- R10: When the reset is released, `fetch_start_o` is 1 for exactly one cycle directly after a cycle with `core_rst_o`=1. During that cycle `fetch_addr_o` is 0.
- R11: While `por_ni` is 0, `core_rst_o` is 1. After power-on, the core leaves reset as soon as the registered reset request is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| por_ni | input | 1 | Power-on reset, active low, asynchronous |
| irq_lvl_i | input | 4 | Asynchronous external interrupt level |
| pil_i | input | 4 | Core's current interrupt priority level |
| trap_en_i | input | 1 | Core trap-enable bit |
| sync_trap_i | input | 1 | Core reports a synchronous trap this cycle |
| rst_req_i | input | 1 | External reset request, active high |
| irq_level_o | output | 4 | Synchronised interrupt level |
| irq_take_o | output | 1 | Interrupt should be taken |
| err_o | output | 1 | Error mode active |
| core_rst_o | output | 1 | Core held in reset |
| fetch_start_o | output | 1 | One-cycle start pulse after reset release |
| fetch_addr_o | output | 32 | First fetch address |

## Verification
Random level, priority and trap-enable triples are checked against a model of the compare. These triples tell a level strictly above the priority apart from one equal to or below it. Directed cases pin down four situations:
- level 0;
- level 15 against priority 15;
- the two-edge latency of the synchroniser;
- the absence of any take while traps are disabled.

Reset pulses of 7 and 8 clocks separate an ignored request from a qualified one. A trap with traps enabled, and a trap with traps disabled, separate a harmless trap from entry into error mode. Error mode is then shown to survive a short reset pulse and to clear on a long one.

// File: rtl/iec_pkg.sv
package iec_pkg;
    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_BOOT  = 2'd1,
        ST_RUN   = 2'd2,
        ST_ERROR = 2'd3
    } ctl_state_e;
endpackage

// File: rtl/iec_level_sync.sv
module iec_level_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             por_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge por_ni) begin
                if (!por_ni) chain_q[s] <= '0;
                else         chain_q[s] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i or negedge por_ni) begin
                if (!por_ni) chain_q[s] <= '0;
                else         chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/iec_rst_qual.sv
module iec_rst_qual #(
    parameter int MIN_RST = 8
) (
    input  logic clk_i,
    input  logic por_ni,
    input  logic rst_req_i,
    output logic req_q_o,
    output logic hit_o
);
    localparam int CNT_W = (MIN_RST > 2) ? $clog2(MIN_RST) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_RST - 1);

    logic             req_q;
    logic [CNT_W-1:0] run_q;

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) begin
            req_q <= 1'b0;
            run_q <= '0;
        end else begin
            req_q <= rst_req_i;
            if (!req_q)             run_q <= '0;
            else if (run_q != LAST) run_q <= run_q + 1'b1;
        end
    end

    assign req_q_o = req_q;
    assign hit_o   = req_q && (run_q == LAST);

    AST_HIT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!por_ni)
        hit_o |-> $past(rst_req_i)); // R8
endmodule

// File: rtl/iec_irq_cmp.sv
module iec_irq_cmp #(
    parameter int LVL_W = 4
) (
    input  logic [LVL_W-1:0] lvl_i,
    input  logic [LVL_W-1:0] pil_i,
    input  logic             enable_i,
    output logic             take_o
);
    localparam logic [LVL_W-1:0] NMI_LVL = '1;

    logic pending, is_nmi, above;

    always_comb begin
        pending = (lvl_i != '0);
        is_nmi  = (lvl_i == NMI_LVL);
        above   = (lvl_i > pil_i);
        take_o  = enable_i && pending && (is_nmi || above);
    end
endmodule

// File: rtl/irq_err_rst_ctrl.sv
module irq_err_rst_ctrl
    import iec_pkg::*;
#(
    parameter int LVL_W     = 4,
    parameter int SYNC_STG  = 2,
    parameter int MIN_RST   = 8,
    parameter int ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BOOT_ADDR = '0
) (
    input  logic              clk_i,
    input  logic              por_ni,
    input  logic [LVL_W-1:0]  irq_lvl_i,
    input  logic [LVL_W-1:0]  pil_i,
    input  logic              trap_en_i,
    input  logic              sync_trap_i,
    input  logic              rst_req_i,
    output logic [LVL_W-1:0]  irq_level_o,
    output logic              irq_take_o,
    output logic              err_o,
    output logic              core_rst_o,
    output logic              fetch_start_o,
    output logic [ADDR_W-1:0] fetch_addr_o
);
    ctl_state_e state_q, state_d;
    logic [LVL_W-1:0] lvl_s;
    logic req_q, rst_hit, cmp_en;

    iec_level_sync #(.WIDTH(LVL_W), .STAGES(SYNC_STG)) u_sync (
        .clk_i   (clk_i),
        .por_ni  (por_ni),
        .async_i (irq_lvl_i),
        .sync_o  (lvl_s)
    );

    iec_rst_qual #(.MIN_RST(MIN_RST)) u_qual (
        .clk_i     (clk_i),
        .por_ni    (por_ni),
        .rst_req_i (rst_req_i),
        .req_q_o   (req_q),
        .hit_o     (rst_hit)
    );

    assign cmp_en = trap_en_i && (state_q == ST_RUN);

    iec_irq_cmp #(.LVL_W(LVL_W)) u_cmp (
        .lvl_i    (lvl_s),
        .pil_i    (pil_i),
        .enable_i (cmp_en),
        .take_o   (irq_take_o)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET: if (!req_q)                     state_d = ST_BOOT;
            ST_BOOT:  if (rst_hit)                    state_d = ST_RESET;
                      else                            state_d = ST_RUN;
            ST_RUN:   if (rst_hit)                    state_d = ST_RESET;
                      else if (sync_trap_i && !trap_en_i) state_d = ST_ERROR;
            ST_ERROR: if (rst_hit)                    state_d = ST_RESET;
            default:                                  state_d = ST_RESET;
        endcase
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) state_q <= ST_RESET;
        else         state_q <= state_d;
    end

    always_comb begin
        core_rst_o    = 1'b0;
        fetch_start_o = 1'b0;
        err_o         = 1'b0;
        fetch_addr_o  = BOOT_ADDR;
        unique case (state_q)
            ST_RESET: core_rst_o    = 1'b1;
            ST_BOOT:  fetch_start_o = 1'b1;
            ST_RUN:   ;
            ST_ERROR: err_o         = 1'b1;
            default:  core_rst_o    = 1'b1;
        endcase
    end

    assign irq_level_o = lvl_s;

    AST_NO_IDLE_TAKE: assert property (@(posedge clk_i) disable iff (!por_ni)
        irq_take_o |-> (irq_level_o != '0)); // R2
    AST_TAKE_NEEDS_ET: assert property (@(posedge clk_i) disable iff (!por_ni)
        irq_take_o |-> (trap_en_i && !err_o && !core_rst_o)); // R3
    AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!por_ni)
        (err_o && !rst_hit) |=> err_o); // R7
    AST_SHORT_RST_IGNORED: assert property (@(posedge clk_i) disable iff (!por_ni)
        (!core_rst_o && !rst_hit) |=> !core_rst_o); // R9
    AST_START_AFTER_RST: assert property (@(posedge clk_i) disable iff (!por_ni)
        fetch_start_o |-> $past(core_rst_o)); // R10
    AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!por_ni)
        fetch_start_o |=> !fetch_start_o); // R10
endmodule

// File: tb/tb_irq_err_rst_ctrl.sv
module tb_irq_err_rst_ctrl;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic [3:0]  lvl = '0, pil = '0;
    logic        et = 1'b0, trap = 1'b0, rreq = 1'b0;
    logic [3:0]  lvl_o;
    logic        take, err, crst, fstart;
    logic [31:0] faddr;

    int n_cmp = 0, n_bad = 0;
    int n_start = 0, n_rst_seen = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    irq_err_rst_ctrl dut (
        .clk_i(clk), .por_ni(por_n), .irq_lvl_i(lvl), .pil_i(pil),
        .trap_en_i(et), .sync_trap_i(trap), .rst_req_i(rreq),
        .irq_level_o(lvl_o), .irq_take_o(take), .err_o(err),
        .core_rst_o(crst), .fetch_start_o(fstart), .fetch_addr_o(faddr)
    );

    function automatic logic model_take(logic [3:0] l, logic [3:0] p, logic e);
        if (!e || l == 4'd0) return 1'b0;
        if (l == 4'hF)       return 1'b1;
        return l > p;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (por_n && fstart) begin
            n_start++;
            chk("R10 addr", faddr, 32'h0);
        end
        if (por_n && crst) n_rst_seen++;
    end

    task automatic rst_pulse(int n);
        rreq = 1'b1;
        cyc(n);
        rreq = 1'b0;
        cyc(6);
    endtask

    initial begin
        int s0, r0;
        void'($urandom(32'hC0FFEE));
        cyc(3);
        chk("R11 por core_rst", {31'b0, crst}, 32'd1);
        chk("R11 por err", {31'b0, err}, 32'd0);
        por_n = 1'b1;
        cyc(4);
        chk("R10 start count after por", n_start, 1);
        chk("R11 left reset", {31'b0, crst}, 32'd0);

        // R1 latency
        lvl = 4'h3; cyc(3);
        lvl = 4'h9; cyc(1);
        chk("R1 one edge", lvl_o, 4'h3);
        cyc(1);
        chk("R1 two edges", lvl_o, 4'h9);

        // directed corners
        et = 1'b1; pil = 4'hF; lvl = 4'hF; cyc(3);
        chk("R5 nmi over pil 15", {31'b0, take}, 32'd1);
        lvl = 4'h0; pil = 4'h0; cyc(3);
        chk("R2 idle level", {31'b0, take}, 32'd0);
        lvl = 4'h5; pil = 4'h5; cyc(3);
        chk("R4 equal not taken", {31'b0, take}, 32'd0);
        et = 1'b0; lvl = 4'hF; cyc(3);
        chk("R3 traps disabled", {31'b0, take}, 32'd0);

        // random compare
        for (int i = 0; i < 60; i++) begin
            logic [3:0] l, p;
            logic e;
            l = 4'($urandom); p = 4'($urandom); e = 1'($urandom);
            lvl = l; pil = p; et = e;
            cyc(3);
            chk("R1 level", lvl_o, l);
            chk(l == 4'hF ? "R5 random" : "R4 random", {31'b0, take}, {31'b0, model_take(l, p, e)});
        end

        // trap with traps enabled: harmless
        et = 1'b1; trap = 1'b1; cyc(1); trap = 1'b0; cyc(1);
        chk("R6 trap with et", {31'b0, err}, 32'd0);
        // trap with traps disabled: error
        et = 1'b0; trap = 1'b1; cyc(1); trap = 1'b0;
        chk("R6 error entry", {31'b0, err}, 32'd1);
        et = 1'b1; lvl = 4'hF; pil = 4'h0; cyc(4);
        chk("R7 no take in error", {31'b0, take}, 32'd0);
        chk("R7 error held", {31'b0, err}, 32'd1);

        // short reset ignored
        s0 = n_start; r0 = n_rst_seen;
        rst_pulse(7);
        chk("R9 no core reset", n_rst_seen, r0);
        chk("R9 no start", n_start, s0);
        chk("R9 error kept", {31'b0, err}, 32'd1);

        // qualified reset
        rst_pulse(8);
        chk("R8 core reset seen", {31'b0, n_rst_seen > r0}, 32'd1);
        chk("R8 error cleared", {31'b0, err}, 32'd0);
        chk("R10 one start", n_start, s0 + 1);
        chk("R10 running", {31'b0, crst}, 32'd0);
        cyc(2);
        chk("R3 takes again in run", {31'b0, take}, 32'd1);

        // short reset from run
        s0 = n_start;
        rst_pulse(3);
        chk("R9 run unchanged", n_start, s0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule